// File: doc/BRIEF.md
# Block Cipher Register Front End

This block is the memory-mapped slave that sits between a 32-bit processor bus and a 64-bit block cipher core. It holds the key words, the chaining vector, the mode controls, a length word, a DMA mask and a revision word. It also runs programmed-I/O transfers one block at a time. Software writes the two halves of an input block through a data window. The write to the upper half hands the block to the core over a valid/ready port. When the core returns a result, the block keeps it until software reads both halves back through the same window.

Block flow is paced by two interrupt sources. One says the core has taken the last input block and can accept another. The other says a result is waiting. Each source has a status bit and an enable bit, and the interrupt line is asserted while any enabled status bit is set. The key words are placed at descending addresses with each pair of words swapped, so that software can store a key held as a byte string without reordering it. Every key write takes effect, including writes made while a block is in flight.

Top module: `blkcph_regif`

## Requirements
- R1: After reset, interrupt status reads 0x2 (only the data-in bit set), interrupt enable reads 0, the interrupt line is low, and control reads 0x2 (input ready, no result held).
- R2: Key word n (0 to 5) is written and read at offset 0x14 - 4*(n XOR 1), so words 0 to 5 sit at 0x10, 0x14, 0x08, 0x0C, 0x00 and 0x04. Word n drives bits 32n+31:32n of the core key. Every key write updates the key, even while an input block is pending.
- R3: Chaining words 0 and 1 at 0x18 and 0x1C, the length word at 0x24 and the DMA mask at 0x34 read back what was written. The DMA mask keeps only bits 7:5. Control at 0x20 stores chaining mode in bit 4, triple-key mode in bit 3 and direction (1 = encrypt) in bit 2, and these drive the core mode outputs. Control bits 1 and 0 are read-only.
- R4: Data words are written at 0x28 (bits 31:0 of the block) and 0x2C (bits 63:32). In the cycle after the write to 0x2C, core_in_valid is high and core_in_data holds the block. The block stays stable until the core takes it. Data writes made while a block is pending are ignored.
- R5: When the core takes the block, core_in_valid falls, interrupt status bit 1 (data-in) is set, and control bit 1 (input ready) reads 1 again.
- R6: A core result is accepted only while no result is held (core_out_ready is high only then). Acceptance sets interrupt status bit 2 (data-out) and control bit 0. Reads of 0x28 and 0x2C return bits 31:0 and 63:32 of the result, and the read of 0x2C frees the holding register.
- R7: Writing the status register at 0x3C clears every source bit written as 0 and leaves every bit written as 1 unchanged. If a source event happens in the same cycle as the clear, the bit stays set.
- R8: The interrupt enable register at 0x40 keeps only bit 1 (data-in) and bit 2 (data-out). The interrupt line is high exactly while some status bit and its enable bit are both set.
- R9: The revision word at 0x30 reports the major version in bits 10:8 and the minor version in bits 5:0, and writes to it have no effect.
- R10: Reads of unmapped offsets return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| irq | output | 1 | Interrupt request |
| core_key | output | 192 | Key words to the core |
| core_iv | output | 64 | Chaining vector to the core |
| core_cbc | output | 1 | Chaining mode select |
| core_tdes | output | 1 | Triple-key mode select |
| core_encrypt | output | 1 | Direction, 1 = encrypt |
| core_in_valid | output | 1 | Input block valid |
| core_in_ready | input | 1 | Core accepts the input block |
| core_in_data | output | 64 | Input block |
| core_out_valid | input | 1 | Core result valid |
| core_out_ready | output | 1 | Result holding register empty |
| core_out_data | input | 64 | Core result |

## Verification
The hardest case to reach is a status clear that lands in the same cycle as a core event setting that bit, because the bus write and the core handshake come from independent sides. The bench drives the status write and the result-valid pulse from the same negedge, so both reach one clock edge, and then reads the bit back. A second hard case is bus traffic during a pending block. The bench holds core_in_ready low and then rewrites a data word and a key word, checking that the data write is ignored and that the key write takes effect.

// File: rtl/blkcph_pkg.sv
package blkcph_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_KEY_END = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_IV0     = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_IV1     = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_LEN     = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_DAT0    = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_DAT1    = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_REV     = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_DMA     = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_ISTS    = 8'h3C;
  localparam logic [ADDR_W-1:0] OFS_IEN     = 8'h40;

  // control field positions
  localparam int CB_CBC    = 4;
  localparam int CB_TDES   = 3;
  localparam int CB_DIR    = 2;
  localparam int CB_INRDY  = 1;
  localparam int CB_OUTRDY = 0;

  // interrupt source positions in status and enable
  localparam int IB_DIN  = 1;
  localparam int IB_DOUT = 2;

  // key word n sits below the window end, pairs swapped
  function automatic logic [ADDR_W-1:0] key_ofs(input int unsigned n);
    return OFS_KEY_END - ADDR_W'((n ^ 1) * 4);
  endfunction

  function automatic logic [WORD_W-1:0] rev_word(input logic [2:0] maj,
                                                 input logic [5:0] mnr);
    return {21'b0, maj, 2'b00, mnr};
  endfunction
endpackage

// File: rtl/blkcph_keyfile.sv
module blkcph_keyfile
  import blkcph_pkg::*;
#(
  parameter int unsigned NWORDS = 6,
  localparam int unsigned KEY_W = NWORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [KEY_W-1:0]  key,
  output logic              hit,
  output logic [WORD_W-1:0] rdata
);
  logic [NWORDS-1:0] word_hit;

  for (genvar n = 0; n < NWORDS; n++) begin : g_word
    assign word_hit[n] = (addr == key_ofs(n));

    always_ff @(posedge clk) begin
      if (!rst_n) key[n*WORD_W +: WORD_W] <= '0;
      else if (wr_en && word_hit[n]) key[n*WORD_W +: WORD_W] <= wdata;
    end

    // every key write lands, whatever else is going on
    assert_key_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && word_hit[n]) |=> key[n*WORD_W +: WORD_W] == $past(wdata));
  end

  always_comb begin
    rdata = '0;
    for (int n = 0; n < NWORDS; n++)
      if (word_hit[n]) rdata = key[n*WORD_W +: WORD_W];
  end
  assign hit = |word_hit;
endmodule

// File: rtl/blkcph_pio.sv
module blkcph_pio
  import blkcph_pkg::*;
#(
  parameter int unsigned BLK_W = 64,
  localparam int unsigned HALF_W = BLK_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  input  logic              pop,
  input  logic              core_in_ready,
  input  logic              core_out_valid,
  input  logic [BLK_W-1:0]  core_out_data,
  output logic              core_in_valid,
  output logic [BLK_W-1:0]  core_in_data,
  output logic              core_out_ready,
  output logic [BLK_W-1:0]  res_data,
  output logic              in_full,
  output logic              out_full,
  output logic              launch_evt,
  output logic              din_evt,
  output logic              dout_evt
);
  logic [HALF_W-1:0] in_lo, in_hi;

  assign launch_evt = wr_hi && !in_full;
  assign din_evt    = in_full && core_in_ready;
  assign dout_evt   = core_out_valid && !out_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_lo   <= '0;
      in_hi   <= '0;
      in_full <= 1'b0;
    end else begin
      if (wr_lo && !in_full) in_lo <= wdata;
      if (launch_evt) begin
        in_hi   <= wdata;
        in_full <= 1'b1;
      end else if (din_evt) begin
        in_full <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_data <= '0;
      out_full <= 1'b0;
    end else if (dout_evt) begin
      res_data <= core_out_data;
      out_full <= 1'b1;
    end else if (pop) begin
      out_full <= 1'b0;
    end
  end

  assign core_in_valid  = in_full;
  assign core_in_data   = {in_hi, in_lo};
  assign core_out_ready = !out_full;

  assert_in_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (core_in_valid && !core_in_ready) |=> core_in_valid && $stable(core_in_data));
  assert_take_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_in_valid && core_in_ready) |=> !core_in_valid);
  assert_result_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_out_valid && core_out_ready) |=> !core_out_ready && res_data == $past(core_out_data));
endmodule

// File: rtl/blkcph_irq.sv
module blkcph_irq #(
  parameter int unsigned NSRC = 2,
  parameter logic [NSRC-1:0] STS_RST = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sts_wr,
  input  logic            en_wr,
  input  logic [NSRC-1:0] wbits,
  input  logic [NSRC-1:0] evt,
  output logic [NSRC-1:0] sts_q,
  output logic [NSRC-1:0] en_q,
  output logic            irq
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n)                    sts_q[i] <= STS_RST[i];
      else if (evt[i])               sts_q[i] <= 1'b1;
      else if (sts_wr && !wbits[i])  sts_q[i] <= 1'b0;
    end

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> sts_q[i]);
    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr && !wbits[i] && !evt[i]) |=> !sts_q[i]);
    assert_one_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr && wbits[i]) |=> sts_q[i] == $past(sts_q[i]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= wbits;
  end

  assign irq = |(sts_q & en_q);

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
endmodule

// File: rtl/blkcph_regif.sv
module blkcph_regif
  import blkcph_pkg::*;
#(
  parameter int unsigned KEY_WORDS = 6,
  parameter int unsigned BLK_W     = 64,
  parameter int unsigned REV_MAJOR = 2,
  parameter int unsigned REV_MINOR = 6,
  parameter logic [31:0] DMA_KEEP  = 32'h0000_00E0,
  localparam int unsigned KEY_W  = KEY_WORDS * WORD_W,
  localparam int unsigned HALF_W = BLK_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq,
  output logic [KEY_W-1:0]  core_key,
  output logic [BLK_W-1:0]  core_iv,
  output logic              core_cbc,
  output logic              core_tdes,
  output logic              core_encrypt,
  output logic              core_in_valid,
  input  logic              core_in_ready,
  output logic [BLK_W-1:0]  core_in_data,
  input  logic              core_out_valid,
  output logic              core_out_ready,
  input  logic [BLK_W-1:0]  core_out_data
);
  logic wr, rd;
  assign wr = bus_sel && bus_wr;
  assign rd = bus_sel && !bus_wr;

  // key words
  logic              key_hit;
  logic [WORD_W-1:0] key_rdata;
  blkcph_keyfile #(.NWORDS(KEY_WORDS)) u_key (
    .clk(clk), .rst_n(rst_n), .wr_en(wr), .addr(bus_addr), .wdata(bus_wdata),
    .key(core_key), .hit(key_hit), .rdata(key_rdata)
  );

  // plain storage registers
  logic [HALF_W-1:0] iv0_q, iv1_q;
  logic [2:0]        mode_q;   // {cbc, tdes, dir}
  logic [WORD_W-1:0] len_q, dma_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iv0_q  <= '0;
      iv1_q  <= '0;
      mode_q <= '0;
      len_q  <= '0;
      dma_q  <= '0;
    end else if (wr) begin
      case (bus_addr)
        OFS_IV0:  iv0_q  <= bus_wdata;
        OFS_IV1:  iv1_q  <= bus_wdata;
        OFS_CTRL: mode_q <= bus_wdata[CB_CBC:CB_DIR];
        OFS_LEN:  len_q  <= bus_wdata;
        OFS_DMA:  dma_q  <= bus_wdata & DMA_KEEP;
        default:  ;
      endcase
    end
  end

  assign core_iv      = {iv1_q, iv0_q};
  assign core_cbc     = mode_q[2];
  assign core_tdes    = mode_q[1];
  assign core_encrypt = mode_q[0];

  // programmed-I/O block path
  logic              in_full, out_full, launch_evt, din_evt, dout_evt, pop;
  logic [BLK_W-1:0]  res_data;
  assign pop = rd && (bus_addr == OFS_DAT1) && out_full;

  blkcph_pio #(.BLK_W(BLK_W)) u_pio (
    .clk(clk), .rst_n(rst_n),
    .wr_lo(wr && bus_addr == OFS_DAT0), .wr_hi(wr && bus_addr == OFS_DAT1),
    .wdata(bus_wdata), .pop(pop),
    .core_in_ready(core_in_ready), .core_out_valid(core_out_valid),
    .core_out_data(core_out_data),
    .core_in_valid(core_in_valid), .core_in_data(core_in_data),
    .core_out_ready(core_out_ready), .res_data(res_data),
    .in_full(in_full), .out_full(out_full),
    .launch_evt(launch_evt), .din_evt(din_evt), .dout_evt(dout_evt)
  );

  // interrupt sources: index 0 = data-in, index 1 = data-out
  logic [1:0] sts_q, en_q;
  blkcph_irq #(.NSRC(2), .STS_RST(2'b01)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .sts_wr(wr && bus_addr == OFS_ISTS), .en_wr(wr && bus_addr == OFS_IEN),
    .wbits({bus_wdata[IB_DOUT], bus_wdata[IB_DIN]}),
    .evt({dout_evt, din_evt}),
    .sts_q(sts_q), .en_q(en_q), .irq(irq)
  );

  // read mux
  logic [WORD_W-1:0] ctrl_word, src_word_s, src_word_e;
  always_comb begin
    ctrl_word = '0;
    ctrl_word[CB_CBC:CB_DIR] = mode_q;
    ctrl_word[CB_INRDY]      = !in_full;
    ctrl_word[CB_OUTRDY]     = out_full;
    src_word_s = '0;
    src_word_s[IB_DIN]  = sts_q[0];
    src_word_s[IB_DOUT] = sts_q[1];
    src_word_e = '0;
    src_word_e[IB_DIN]  = en_q[0];
    src_word_e[IB_DOUT] = en_q[1];
  end

  always_comb begin
    bus_rdata = '0;
    if (key_hit) bus_rdata = key_rdata;
    else begin
      case (bus_addr)
        OFS_IV0:  bus_rdata = iv0_q;
        OFS_IV1:  bus_rdata = iv1_q;
        OFS_CTRL: bus_rdata = ctrl_word;
        OFS_LEN:  bus_rdata = len_q;
        OFS_DAT0: bus_rdata = res_data[HALF_W-1:0];
        OFS_DAT1: bus_rdata = res_data[BLK_W-1:HALF_W];
        OFS_REV:  bus_rdata = rev_word(3'(REV_MAJOR), 6'(REV_MINOR));
        OFS_DMA:  bus_rdata = dma_q;
        OFS_ISTS: bus_rdata = src_word_s;
        OFS_IEN:  bus_rdata = src_word_e;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assert_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    launch_evt |=> core_in_valid && core_in_data[BLK_W-1:HALF_W] == $past(bus_wdata));
  assert_pop_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> core_out_ready);
  assert_busy_ignores_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == OFS_DAT0 && in_full) |=> $stable(core_in_data));
endmodule

// File: tb/tb_blkcph_regif.sv
module tb_blkcph_regif;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         irq;
  logic [191:0] core_key;
  logic [63:0]  core_iv, core_in_data;
  logic         core_cbc, core_tdes, core_encrypt, core_in_valid, core_out_ready;
  logic         core_in_ready = 1'b0, core_out_valid = 1'b0;
  logic [63:0]  core_out_data = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  blkcph_regif dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .core_key(core_key), .core_iv(core_iv), .core_cbc(core_cbc),
    .core_tdes(core_tdes), .core_encrypt(core_encrypt),
    .core_in_valid(core_in_valid), .core_in_ready(core_in_ready),
    .core_in_data(core_in_data), .core_out_valid(core_out_valid),
    .core_out_ready(core_out_ready), .core_out_data(core_out_data)
  );

  // {offset, write value, expected read-back}
  localparam logic [71:0] VEC [15] = '{
    {8'h10, 32'h1111_0000, 32'h1111_0000},
    {8'h14, 32'h1111_0001, 32'h1111_0001},
    {8'h08, 32'h1111_0002, 32'h1111_0002},
    {8'h0C, 32'h1111_0003, 32'h1111_0003},
    {8'h00, 32'h1111_0004, 32'h1111_0004},
    {8'h04, 32'h1111_0005, 32'h1111_0005},
    {8'h18, 32'hA5A5_0018, 32'hA5A5_0018},
    {8'h1C, 32'h5A5A_001C, 32'h5A5A_001C},
    {8'h20, 32'hFFFF_FFFF, 32'h0000_001E},
    {8'h24, 32'h0000_0040, 32'h0000_0040},
    {8'h34, 32'hFFFF_FFFF, 32'h0000_00E0},
    {8'h40, 32'hFFFF_FFFF, 32'h0000_0006},
    {8'h30, 32'hFFFF_FFFF, 32'h0000_0206},
    {8'h44, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h38, 32'h1234_5678, 32'h0000_0000}
  };

  function automatic logic [7:0] kaddr(input int n);
    int partner = (n % 2 == 0) ? n + 1 : n - 1;
    return 8'h14 - 8'(partner * 4);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(8'h3C, r); chk("R1 status", 64'(r), 64'h2);
    rd(8'h40, r); chk("R1 enable", 64'(r), 64'h0);
    rd(8'h20, r); chk("R1 control", 64'(r), 64'h2);
    chk("R1 irq", 64'(irq), 64'h0);

    // register table walk: R2 R3 R8 R9 R10
    for (int i = 0; i < 15; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], r);
      chk($sformatf("R3/R8/R9/R10/R2 readback %h", VEC[i][71:64]), 64'(r), 64'(VEC[i][31:0]));
    end
    for (int n = 0; n < 6; n++) begin
      rd(kaddr(n), r);
      chk("R2 key address", 64'(r), 64'(32'h1111_0000 + n));
      chk("R2 key output", 64'(core_key[n*32 +: 32]), 64'(32'h1111_0000 + n));
    end
    chk("R3 iv output", core_iv, 64'h5A5A_001C_A5A5_0018);
    chk("R3 mode outputs", 64'({core_cbc, core_tdes, core_encrypt}), 64'h7);
    rd(8'h24, r); chk("R10 length untouched by unmapped writes", 64'(r), 64'h40);
    chk("R8 irq with data-in enabled", 64'(irq), 64'h1);

    wr(8'h20, 32'h0000_0014);
    chk("R3 mode cbc+enc", 64'({core_cbc, core_tdes, core_encrypt}), 64'h5);
    rd(8'h20, r); chk("R3 control readback", 64'(r), 64'h16);
    wr(8'h40, 32'h0);
    wr(8'h3C, 32'h0);
    rd(8'h3C, r); chk("R7 clear by zero", 64'(r), 64'h0);
    chk("R8 irq low", 64'(irq), 64'h0);

    // R4 launch with core stalled
    wr(8'h28, 32'hCAFE_0001);
    wr(8'h2C, 32'hBEEF_0002);
    chk("R4 valid after launch", 64'(core_in_valid), 64'h1);
    chk("R4 block data", core_in_data, 64'hBEEF_0002_CAFE_0001);
    rd(8'h20, r); chk("R4 input not ready", 64'(r), 64'h14);
    wr(8'h28, 32'hDEAD_DEAD);
    wr(8'h2C, 32'hDEAD_DEAD);
    chk("R4 busy writes ignored", core_in_data, 64'hBEEF_0002_CAFE_0001);
    wr(8'h10, 32'h7777_0000);
    chk("R2 key write while pending", 64'(core_key[31:0]), 64'h7777_0000);
    rd(8'h3C, r); chk("R5 no data-in before take", 64'(r), 64'h0);

    // R5 core takes the block
    @(negedge clk) core_in_ready = 1;
    @(negedge clk) core_in_ready = 0;
    chk("R5 valid drops", 64'(core_in_valid), 64'h0);
    rd(8'h3C, r); chk("R5 data-in set", 64'(r), 64'h2);
    rd(8'h20, r); chk("R5 input ready", 64'(r), 64'h16);
    wr(8'h40, 32'h2);
    chk("R8 irq on data-in", 64'(irq), 64'h1);
    wr(8'h40, 32'h4);
    chk("R8 irq masked", 64'(irq), 64'h0);

    // R6 result return
    chk("R6 ready when empty", 64'(core_out_ready), 64'h1);
    @(negedge clk) begin core_out_valid = 1; core_out_data = 64'h0123_4567_89AB_CDEF; end
    @(negedge clk) core_out_valid = 0;
    chk("R6 ready drops when held", 64'(core_out_ready), 64'h0);
    chk("R8 irq on data-out", 64'(irq), 64'h1);
    rd(8'h3C, r); chk("R6 data-out set", 64'(r), 64'h6);
    rd(8'h20, r); chk("R6 output ready bit", 64'(r), 64'h17);
    @(negedge clk) begin core_out_valid = 1; core_out_data = 64'hFFFF_0000_FFFF_0000; end
    @(negedge clk) core_out_valid = 0;
    rd(8'h28, r); chk("R6 low half", 64'(r), 64'h89AB_CDEF);
    chk("R6 low read keeps result", 64'(core_out_ready), 64'h0);
    rd(8'h2C, r); chk("R6 high half, second result refused", 64'(r), 64'h0123_4567);
    chk("R6 high read frees", 64'(core_out_ready), 64'h1);

    // R7 write-one keeps
    wr(8'h3C, 32'h0000_0004);
    rd(8'h3C, r); chk("R7 one keeps data-out, zero clears data-in", 64'(r), 64'h4);
    wr(8'h3C, 32'h0);
    rd(8'h3C, r); chk("R7 cleared", 64'(r), 64'h0);

    // R7 set wins over same-cycle clear
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h3C; bus_wdata = 32'h0;
    core_out_valid = 1; core_out_data = 64'h1;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; core_out_valid = 0;
    rd(8'h3C, r); chk("R7 set wins", 64'(r), 64'h4);
    rd(8'h2C, r);

    // R1 reset mid-run
    @(negedge clk) rst_n = 0;
    @(negedge clk) rst_n = 1;
    rd(8'h3C, r); chk("R1 status after reset", 64'(r), 64'h2);
    chk("R1 irq after reset", 64'(irq), 64'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule